// File: doc/BRIEF.md
# Future-Aligned Schedule Base Time Calculator

This block moves a requested schedule start time into the future without changing its phase. It takes three inputs: the requested start time, a cycle period and the current value of a free-running nanosecond counter. From these it returns a start time that is at least two cycle periods ahead of the current time. The returned time differs from the request by a whole number of cycle periods. A scheduler uses it to pick a base time that the timing hardware can still reach.

A single-cycle `start` pulse captures the three inputs. The block has no divider. It first doubles a chunk of cycle periods until the chunk covers the gap to the threshold. It then walks the chunk back down by halving, adding a chunk whenever the running value stays below the threshold. It ends by adding one more cycle. A request that is already far enough ahead is returned unchanged in one cycle. A zero cycle period is flagged as an error. The result, `done` and the error flag stay registered until the next accepted `start`.

Top module: `sched_base_align`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `err` are 0 and `result` is 0.
- R2: The threshold is `now_time + 2*cycle_time`. When `req_time` is at or above the threshold and `cycle_time` is nonzero, the edge that accepts `start` sets `done`=1, `err`=0 and `result`=`req_time`. This includes the case where `req_time` equals the threshold exactly.
- R3: When `req_time` is below the threshold, the result equals `req_time + N*cycle_time` for an integer N. It also satisfies threshold <= result < threshold + cycle_time, and it equals the threshold exactly when the gap is a whole number of cycles. Inputs are assumed to satisfy `now_time + 3*cycle_time < 2^64`.
- R4: A `cycle_time` of 0 sets `done`=1, `err`=1 and `result`=0 on the accepting edge, and the block performs no search.
- R5: An accepted `start` clears `done` and `err`. `result`, `done` and `err` then hold their values until the next accepted `start`.
- R6: A `start` pulse while `busy` is 1 is ignored, and the pending computation finishes with the values captured first.
- R7: `busy` and `done` are never 1 together, and a search finishes within 200 clock cycles of its `start`.
- R8: The doubling search stops after at most 66 doublings of the chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, accepted when not busy |
| req_time | input | 64 | Requested start time, ns |
| cycle_time | input | 32 | Cycle period, ns |
| now_time | input | 64 | Current time from the free-running counter, ns |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until next accepted start |
| err | output | 1 | Cycle period was zero |
| result | output | 64 | Future-aligned start time |

## Verification
On every cycle, the assertions check several properties. They check that a completed search lands in the window between the captured threshold and one cycle above it. They check that the error flag only appears together with `done` and a zero result. They check that outputs hold while idle and that captured operands stay frozen while busy. They also check that the doubling count stays bounded. Only the bench scenarios can show that the result is exactly the smallest aligned time at or above the threshold. The same holds for the equality boundaries, the pass-through of far-future requests, and the recovery after ignored or repeated starts. The bench computes all of these by division and compares them against the design.

// File: rtl/sba_pkg.sv
package sba_pkg;
  parameter int TIME_W  = 64;
  parameter int CYC_W   = 32;
  parameter int EXT_W   = TIME_W + 3;
  parameter int LVL_W   = 7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GROW   = 2'd1,
    ST_SHRINK = 2'd2
  } sba_state_e;
endpackage

// File: rtl/sba_thresh.sv
module sba_thresh #(
  parameter int TW = 64,
  parameter int CW = 32,
  parameter int XW = TW + 3
) (
  input  logic [TW-1:0] req_i,
  input  logic [CW-1:0] cyc_i,
  input  logic [TW-1:0] now_i,
  output logic [XW-1:0] thr_o,
  output logic [XW-1:0] gap_o,
  output logic          ahead_o,
  output logic          zero_o
);
  logic [XW-1:0] req_x, cyc_x, now_x;

  always_comb begin
    req_x   = {{(XW-TW){1'b0}}, req_i};
    cyc_x   = {{(XW-CW){1'b0}}, cyc_i};
    now_x   = {{(XW-TW){1'b0}}, now_i};
    thr_o   = now_x + (cyc_x << 1);
    ahead_o = (req_x >= thr_o);
    gap_o   = ahead_o ? '0 : (thr_o - req_x);
    zero_o  = (cyc_i == '0);
  end
endmodule

// File: rtl/sba_search.sv
module sba_search
  import sba_pkg::*;
#(
  parameter int TW = 64,
  parameter int CW = 32,
  parameter int XW = TW + 3,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] req_i,
  input  logic [CW-1:0] cyc_i,
  input  logic [XW-1:0] thr_i,
  input  logic [XW-1:0] gap_i,
  input  logic          ahead_i,
  input  logic          zero_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [TW-1:0] res_o
);
  localparam int MAX_LVL = TW + 2;

  sba_state_e    state;
  logic [XW-1:0] run_q, chunk_q, thr_q, gap_q, cyc_q;
  logic [LW-1:0] lvl_q;
  logic          pass_q;
  logic [XW-1:0] sum_chunk, sum_cyc;

  always_comb begin
    sum_chunk = run_q + chunk_q;
    sum_cyc   = run_q + cyc_q;
  end

  assign busy_o = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      run_q   <= '0;
      chunk_q <= '0;
      thr_q   <= '0;
      gap_q   <= '0;
      cyc_q   <= '0;
      lvl_q   <= '0;
      pass_q  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      res_o   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            pass_q <= 1'b0;
            thr_q  <= thr_i;
            cyc_q  <= {{(XW-CW){1'b0}}, cyc_i};
            if (zero_i) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              res_o  <= '0;
            end else if (ahead_i) begin
              done_o <= 1'b1;
              pass_q <= 1'b1;
              res_o  <= req_i;
            end else begin
              run_q   <= {{(XW-TW){1'b0}}, req_i};
              chunk_q <= {{(XW-CW){1'b0}}, cyc_i};
              gap_q   <= gap_i;
              lvl_q   <= '0;
              state   <= ST_GROW;
            end
          end
        end
        ST_GROW: begin
          if (chunk_q < gap_q) begin
            chunk_q <= chunk_q << 1;
            lvl_q   <= lvl_q + 1'b1;
          end else begin
            state <= ST_SHRINK;
          end
        end
        ST_SHRINK: begin
          if (sum_chunk < thr_q) begin
            run_q <= sum_chunk;
          end else if (lvl_q == '0) begin
            res_o  <= sum_cyc[TW-1:0];
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            chunk_q <= chunk_q >> 1;
            lvl_q   <= lvl_q - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  window_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(done_o) && !err_o && !pass_q) |->
      (({3'b0, res_o} >= thr_q) && ({3'b0, res_o} < thr_q + cyc_q)));

  // R4
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && res_o == '0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> (done_o && $stable(res_o) && $stable(err_o)));

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ($stable(thr_q) && $stable(cyc_q)));

  // R7
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R8
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= LW'(MAX_LVL));
endmodule

// File: rtl/sched_base_align.sv
module sched_base_align
  import sba_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int CW = CYC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] req_time,
  input  logic [CW-1:0] cycle_time,
  input  logic [TW-1:0] now_time,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [TW-1:0] result
);
  localparam int XW = TW + 3;
  localparam int LW = $clog2(XW + 1);

  logic [XW-1:0] thr, gap;
  logic          ahead, zero;

  sba_thresh #(.TW(TW), .CW(CW), .XW(XW)) u_thresh (
    .req_i   (req_time),
    .cyc_i   (cycle_time),
    .now_i   (now_time),
    .thr_o   (thr),
    .gap_o   (gap),
    .ahead_o (ahead),
    .zero_o  (zero)
  );

  sba_search #(.TW(TW), .CW(CW), .XW(XW), .LW(LW)) u_search (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .req_i   (req_time),
    .cyc_i   (cycle_time),
    .thr_i   (thr),
    .gap_i   (gap),
    .ahead_i (ahead),
    .zero_i  (zero),
    .busy_o  (busy),
    .done_o  (done),
    .err_o   (err),
    .res_o   (result)
  );
endmodule

// File: tb/sched_base_align_tb.sv
module sched_base_align_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] req_time = '0;
  logic [31:0] cycle_time = '0;
  logic [63:0] now_time = '0;
  logic        busy, done, err;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sched_base_align u_dut (
    .clk(clk), .rst(rst), .start(start), .req_time(req_time),
    .cycle_time(cycle_time), .now_time(now_time),
    .busy(busy), .done(done), .err(err), .result(result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] r, input logic [31:0] c,
                                        input logic [63:0] n);
    logic [63:0] thr, k;
    if (c == 0) return 64'd0;
    thr = n + 2 * 64'(c);
    if (r >= thr) return r;
    k = (thr - r + 64'(c) - 1) / 64'(c);
    return r + k * 64'(c);
  endfunction

  task automatic run(input string req, input logic [63:0] r, input logic [31:0] c,
                     input logic [63:0] n);
    logic [63:0] exp;
    int lat;
    exp = model(r, c, n);
    @(negedge clk);
    req_time = r; cycle_time = c; now_time = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 250) begin
      // R7: busy must cover the wait
      if (!busy) chk("R7 busy", 64'(busy), 64'd1);
      @(negedge clk);
      lat++;
    end
    chk({req, " R7 latency<=200"}, 64'(lat <= 200), 64'd1);
    chk({req, " R7 busy low"}, 64'(busy), 64'd0);
    chk({req, " result"}, result, exp);
    chk({req, " R4 err"}, 64'(err), 64'(c == 0));
    // R5: held on every clock until next start
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({req, " R5 hold"}, result, exp);
      chk({req, " R5 done"}, 64'(done), 64'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 err", 64'(err), 0);
    chk("R1 result", result, 0);

    run("R2 far ahead", 64'd5000, 32'd100, 64'd1000);
    run("R2 equal thr", 64'd1200, 32'd100, 64'd1000);
    run("R3 one below", 64'd1199, 32'd100, 64'd1000);
    run("R3 exact multiple", 64'd200, 32'd100, 64'd1000);
    run("R3 non multiple", 64'd37, 32'd1000, 64'd123456);
    run("R3 large gap", 64'd3, 32'd7, 64'd1000000000000);
    run("R3 cycle one", 64'd0, 32'd1, 64'hFFFF_FFFF_FFFF);
    run("R3 big cycle", 64'd12345, 32'hFFFF_FFFF, 64'h0000_0100_0000_0000);
    run("R4 zero cycle", 64'd777, 32'd0, 64'd1000);
    run("R3 after err", 64'd10, 32'd3, 64'd20);

    // R6: start while busy is ignored
    begin
      logic [63:0] exp;
      int lat;
      exp = model(64'd3, 32'd7, 64'd1000000000000);
      @(negedge clk);
      req_time = 64'd3; cycle_time = 32'd7; now_time = 64'd1000000000000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R6 busy", 64'(busy), 1);
      req_time = 64'd99999; cycle_time = 32'd0; now_time = 64'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 250) begin @(negedge clk); lat++; end
      chk("R6 result", result, exp);
      chk("R6 err", 64'(err), 0);
    end

    // R5: new start clears done
    @(negedge clk);
    req_time = 64'd0; cycle_time = 32'd5; now_time = 64'd1000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 done cleared", 64'(done), 0);
    while (!done) @(negedge clk);
    chk("R5 result", result, model(64'd0, 32'd5, 64'd1000));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule